// File: doc/BRIEF.md
# I2C SCL Timing Divider Generator

This block sets up the SCL timing of an I2C master from a single number, the divide ratio, which is the count of input clocks wanted per SCL period. When a load strobe arrives, the block halves the ratio one step per clock until it is below 16. Each halving raises a power-of-two prescaler exponent by one. Any bit that falls off the bottom during this process is remembered and rounds the result up, so that the SCL period is never shorter than requested. The rounded value is then split into a low count and a high count, each with a fixed offset. The exponent and the two counts are given as separate outputs and are also packed into one timing control word.

Once encoding is done, the block raises a ready flag and runs two counters. A prescaler gives one tick every 2^exponent clocks. A phase generator uses those ticks to give an SCL-shaped reference with one-cycle rise and fall pulses. This reference is for timing only: it does not do clock stretching, arbitration or byte handling. A ratio below 2 cannot be encoded, so it is rejected. When that happens the last good settings stay in place and an error flag is raised.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, ready_o and error_o are 0, exp_o, hi_cnt_o, lo_cnt_o are 0, tick_o is 0 and scl_phase_o is 1.
- R2: exp_o equals the number of right shifts by one needed to bring the loaded ratio below 16.
- R3: Bits shifted out during normalisation are ORed into a sticky bit. The sticky bit is added once to the normalised ratio, giving the rounded ratio R (range 2..16).
- R4: lo_cnt_o = (R >> 1) - 1 and hi_cnt_o = R - lo_cnt_o - 2. As a result, hi_cnt_o equals lo_cnt_o or lo_cnt_o + 1.
- R5: ctrl_word_o holds the constant 8'hA5 in bits 31:24, hi_cnt_o in bits 23:20, lo_cnt_o in bits 19:16 and exp_o in bits 4:0. All other bits are zero.
- R6: A valid load clears ready_o at the next edge. ready_o rises exactly exp+1 clock edges after the load edge, and the new fields appear at the same time.
- R7: A valid load that arrives while encoding is in progress abandons the old encoding and restarts with the new ratio.
- R8: A load with ratio 0 or 1 sets error_o and leaves ready_o and every field unchanged. The next valid load clears error_o.
- R9: While ready_o is 1, tick_o pulses once every 2^exp_o clocks, which means every clock when exp_o is 0. While ready_o is 0, tick_o stays 0.
- R10: While ready_o is 1, scl_phase_o stays high for hi_cnt_o+1 ticks and low for lo_cnt_o+1 ticks. scl_fall_o and scl_rise_o pulse for one cycle together with the matching change. While ready_o is 0, scl_phase_o is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that loads ratio_i |
| ratio_i | input | RATIO_W | Requested input clocks per SCL period |
| ready_o | output | 1 | Encoding complete, fields valid |
| error_o | output | 1 | Last load was rejected |
| exp_o | output | 5 | Prescaler exponent |
| hi_cnt_o | output | 4 | SCL high count |
| lo_cnt_o | output | 4 | SCL low count |
| ctrl_word_o | output | 32 | Packed timing control word |
| tick_o | output | 1 | Prescaled tick |
| scl_phase_o | output | 1 | SCL phase reference, 1 = high |
| scl_rise_o | output | 1 | One-cycle pulse on phase rise |
| scl_fall_o | output | 1 | One-cycle pulse on phase fall |

## Verification
The vector table targets the ratios that decide rounding. The cases are exact powers of two (16, 32, 256), values just past a threshold with a lost low bit (17, 31, 1000), and the all-ones maximum, which rounds up to 16 and therefore gives full counts. A design that drops the sticky bit would report 8 or 15 where 9 or 16 is expected. A design that uses the wrong threshold would be off by one in the exponent and in the measured latency. Directed tests then cover these cases:
- Ratios 0 and 1 must be rejected without disturbing the fields.
- A reload arrives during a long normalisation.
- Real high and low run lengths are measured in clocks. A wrong offset or a wrong tick period shows up here as a run that is too long or too short.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int NORM_BITS = 4;
    localparam int CNT_W     = 4;
    localparam int EXP_W     = 5;
    localparam int WORD_W    = 32;
    localparam int EXP_POS   = 0;
    localparam int LO_POS    = 16;
    localparam int HI_POS    = 20;
    localparam logic [WORD_W-1:0] BASE_PATTERN = 32'hA500_0000;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } timing_fields_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } cnt_pair_t;

    function automatic cnt_pair_t split_counts(input logic [NORM_BITS:0] rounded);
        cnt_pair_t p;
        p.lo = rounded[NORM_BITS:1] - CNT_W'(1);
        p.hi = CNT_W'(rounded - {1'b0, p.lo} - (NORM_BITS+1)'(2));
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input timing_fields_t f);
        return BASE_PATTERN
             | (WORD_W'(f.hi)   << HI_POS)
             | (WORD_W'(f.lo)   << LO_POS)
             | (WORD_W'(f.expo) << EXP_POS);
    endfunction
endpackage

// File: rtl/ratio_normalizer.sv
module ratio_normalizer
    import scl_div_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               ready_o,
    output logic               error_o,
    output timing_fields_t     fields_o
);
    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

    logic [RATIO_W-1:0] work_q;
    logic               sticky_q;
    logic [EXP_W-1:0]   shift_q;
    logic               busy_q;
    logic               above_q;
    logic [NORM_BITS:0] rounded;
    cnt_pair_t          split;
    logic               valid_load;

    assign valid_load = load_i && (ratio_i >= MIN_RATIO);
    assign above_q    = |work_q[RATIO_W-1:NORM_BITS];
    assign rounded    = {1'b0, work_q[NORM_BITS-1:0]} + (NORM_BITS+1)'(sticky_q);
    assign split      = split_counts(rounded);

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q   <= '0;
            sticky_q <= 1'b0;
            shift_q  <= '0;
            busy_q   <= 1'b0;
            ready_o  <= 1'b0;
            error_o  <= 1'b0;
            fields_o <= '0;
        end else if (valid_load) begin
            work_q   <= ratio_i;
            sticky_q <= 1'b0;
            shift_q  <= '0;
            busy_q   <= 1'b1;
            ready_o  <= 1'b0;
            error_o  <= 1'b0;
        end else begin
            if (load_i) begin
                error_o <= 1'b1;
            end
            if (busy_q) begin
                if (above_q) begin
                    work_q   <= work_q >> 1;
                    sticky_q <= sticky_q | work_q[0];
                    shift_q  <= shift_q + EXP_W'(1);
                end else begin
                    busy_q        <= 1'b0;
                    ready_o       <= 1'b1;
                    fields_o.expo <= shift_q;
                    fields_o.hi   <= split.hi;
                    fields_o.lo   <= split.lo;
                end
            end
        end
    end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import scl_div_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [EXP_W-1:0] expo_i,
    output logic             tick_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] mask;

    assign mask   = (RATIO_W'(1) << expo_i) - RATIO_W'(1);
    assign tick_o = run_i && (cnt_q == mask);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             phase_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = phase_o ? hi_i : lo_i;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_o <= 1'b1;
            cnt_q   <= '0;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (tick_i) begin
                if (cnt_q == limit) begin
                    cnt_q   <= '0;
                    phase_o <= !phase_o;
                    rise_o  <= !phase_o;
                    fall_o  <= phase_o;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_div_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               ready_o,
    output logic               error_o,
    output logic [EXP_W-1:0]   exp_o,
    output logic [CNT_W-1:0]   hi_cnt_o,
    output logic [CNT_W-1:0]   lo_cnt_o,
    output logic [WORD_W-1:0]  ctrl_word_o,
    output logic               tick_o,
    output logic               scl_phase_o,
    output logic               scl_rise_o,
    output logic               scl_fall_o
);
    timing_fields_t fields;

    ratio_normalizer #(.RATIO_W(RATIO_W)) u_norm (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .ratio_i  (ratio_i),
        .ready_o  (ready_o),
        .error_o  (error_o),
        .fields_o (fields)
    );

    tick_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ready_o),
        .expo_i (fields.expo),
        .tick_o (tick_o)
    );

    scl_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .run_i   (ready_o),
        .tick_i  (tick_o),
        .hi_i    (fields.hi),
        .lo_i    (fields.lo),
        .phase_o (scl_phase_o),
        .rise_o  (scl_rise_o),
        .fall_o  (scl_fall_o)
    );

    assign exp_o       = fields.expo;
    assign hi_cnt_o    = fields.hi;
    assign lo_cnt_o    = fields.lo;
    assign ctrl_word_o = pack_word(fields);
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_div_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               load_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               ready_o,
    input logic               error_o,
    input logic [EXP_W-1:0]   exp_o,
    input logic [CNT_W-1:0]   hi_cnt_o,
    input logic [CNT_W-1:0]   lo_cnt_o,
    input logic               tick_o,
    input logic               scl_phase_o,
    input logic               scl_rise_o,
    input logic               scl_fall_o
);
    logic bad_ratio;
    assign bad_ratio = ratio_i < RATIO_W'(2);

    a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (load_i && !bad_ratio) |=> !ready_o);

    a_r8_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (load_i && bad_ratio && ready_o) |=>
            (error_o && ready_o && $stable(exp_o) && $stable(hi_cnt_o) && $stable(lo_cnt_o)));

    a_r8_error_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(error_o) |-> $past(load_i && bad_ratio));

    a_r4_split_balance: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> ((hi_cnt_o == lo_cnt_o) || (hi_cnt_o == lo_cnt_o + CNT_W'(1))));

    a_r9_tick_every_clock: assert property (@(posedge clk) disable iff (rst)
        (ready_o && exp_o == '0) |-> tick_o);

    a_r9_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> !tick_o);

    a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scl_rise_o, scl_fall_o}));

    a_r10_fall_goes_low: assert property (@(posedge clk) disable iff (rst)
        scl_fall_o |-> !scl_phase_o);

    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !$past(ready_o)) |-> scl_phase_o);
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .ratio_i     (ratio_i),
    .ready_o     (ready_o),
    .error_o     (error_o),
    .exp_o       (exp_o),
    .hi_cnt_o    (hi_cnt_o),
    .lo_cnt_o    (lo_cnt_o),
    .tick_o      (tick_o),
    .scl_phase_o (scl_phase_o),
    .scl_rise_o  (scl_rise_o),
    .scl_fall_o  (scl_fall_o)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int RATIO_W = 16;
    localparam int NVEC = 12;
    // {ratio[31:16], exp[15:8], hi[7:4], lo[3:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0002_0000, 32'h000A_0044, 32'h000F_0076, 32'h0010_0133,
        32'h0011_0143, 32'h001F_0177, 32'h0020_0233, 32'h0064_0365,
        32'h03E8_0677, 32'hFFFF_0C77, 32'h0003_0010, 32'h0100_0533
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               load_i;
    logic [RATIO_W-1:0] ratio_i;
    logic               ready_o, error_o, tick_o;
    logic [4:0]         exp_o;
    logic [3:0]         hi_cnt_o, lo_cnt_o;
    logic [31:0]        ctrl_word_o;
    logic               scl_phase_o, scl_rise_o, scl_fall_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    scl_timing_gen #(.RATIO_W(RATIO_W)) dut (
        .clk(clk), .rst(rst), .load_i(load_i), .ratio_i(ratio_i),
        .ready_o(ready_o), .error_o(error_o), .exp_o(exp_o),
        .hi_cnt_o(hi_cnt_o), .lo_cnt_o(lo_cnt_o), .ctrl_word_o(ctrl_word_o),
        .tick_o(tick_o), .scl_phase_o(scl_phase_o),
        .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [RATIO_W-1:0] r);
        @(negedge clk);
        ratio_i = r;
        load_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    function automatic logic [31:0] word_of(input int e, input int h, input int l);
        return 32'hA500_0000 | (32'(h) << 20) | (32'(l) << 16) | 32'(e);
    endfunction

    // count high and low run lengths in clocks (steady state)
    task automatic measure(output int hc, output int lc, output int fall_seen);
        while (scl_phase_o == 1'b1) @(negedge clk);
        while (scl_phase_o == 1'b0) @(negedge clk);
        hc = 0;
        while (scl_phase_o == 1'b1) begin hc++; @(negedge clk); end
        fall_seen = int'(scl_fall_o);
        lc = 0;
        while (scl_phase_o == 1'b0) begin lc++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int k, hc, lc, fs, nt;
        rst = 1'b1; load_i = 1'b0; ratio_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ready", ready_o, 0);
        check("R1 error", error_o, 0);
        check("R1 fields", {exp_o, hi_cnt_o, lo_cnt_o}, 0);
        check("R1 tick/phase", {tick_o, scl_phase_o}, 2'b01);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            int e, h, l;
            e = int'(VEC[i][15:8]); h = int'(VEC[i][7:4]); l = int'(VEC[i][3:0]);
            @(negedge clk);
            ratio_i = VEC[i][31:16];
            load_i  = 1'b1;
            @(posedge clk);
            @(negedge clk);
            load_i = 1'b0;
            check("R6 ready drop", ready_o, 0);
            k = 0;
            while (!ready_o && k < 40) begin
                @(posedge clk); k++; @(negedge clk);
            end
            check("R6 latency", k, e + 1);
            check("R2 exponent", exp_o, e);
            check("R3 R4 high count", hi_cnt_o, h);
            check("R3 R4 low count", lo_cnt_o, l);
            check("R5 word", ctrl_word_o, word_of(e, h, l));
        end

        // R10 run lengths, ratio 10 -> exp0 hi4 lo4
        load(16'd10);
        while (!ready_o) @(negedge clk);
        measure(hc, lc, fs);
        check("R10 high run r10", hc, 5);
        check("R10 low run r10", lc, 5);
        check("R10 fall pulse", fs, 1);

        // R10 with prescale: ratio 17 -> exp1 hi4 lo3
        load(16'd17);
        while (!ready_o) @(negedge clk);
        measure(hc, lc, fs);
        check("R10 high run r17", hc, 10);
        check("R10 low run r17", lc, 8);

        // R9 tick period: ratio 32 -> exp2, one tick per 4 clocks
        load(16'd32);
        while (!ready_o) @(negedge clk);
        nt = 0;
        for (int c = 0; c < 40; c++) begin
            nt += int'(tick_o);
            @(negedge clk);
        end
        check("R9 tick count", nt, 10);

        // R8 reject 0 and 1, fields hold (exp2 hi3 lo3)
        load(16'd0);
        check("R8 error on zero", error_o, 1);
        check("R8 ready held", ready_o, 1);
        check("R8 fields held", {exp_o, hi_cnt_o, lo_cnt_o}, {5'd2, 4'd3, 4'd3});
        load(16'd1);
        check("R8 error on one", error_o, 1);
        check("R8 word held", ctrl_word_o, word_of(2, 3, 3));
        load(16'd15);
        check("R8 error cleared", error_o, 0);
        while (!ready_o) @(negedge clk);
        check("R8 new fields", {exp_o, hi_cnt_o, lo_cnt_o}, {5'd0, 4'd7, 4'd6});

        // R9 no tick while busy, R7 restart mid-normalisation
        load(16'hFFFF);
        check("R9 no tick when busy", tick_o, 0);
        check("R10 idle high", scl_phase_o, 1);
        @(negedge clk);
        load(16'd10);
        k = 0;
        while (!ready_o && k < 40) begin
            @(posedge clk); k++; @(negedge clk);
        end
        check("R7 restart latency", k, 1);
        check("R7 restart fields", {exp_o, hi_cnt_o, lo_cnt_o}, {5'd0, 4'd4, 4'd4});

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule